// File: doc/BRIEF.md
# SCL Low-Hold Timeout Timer

This block guards an I2C master against a bus whose clock line is held low for too long, such as a target that stretches the clock and never releases it. While a master transfer is in progress and the enable bit is set, it measures how long SCL has been sampled low without a break. The system clock is first divided by a power of two, chosen by a 4-bit exponent, into timer ticks. Elapsed ticks are compared against a 15-bit limit.

When the elapsed tick count reaches the limit, the block raises a single-cycle pulse for the master sequencer, which raises its timeout status and aborts the transfer. The measurement restarts from zero whenever SCL is seen high, the transfer ends, the enable bit is cleared or the limit is zero. Software normally aims at about 25 ms of SCL wait. It picks the smallest exponent that fits the cycle count into 15 bits and saturates the count at 0x7FFF.

Top module: `scl_stall_timer`

## Requirements
- R1: After reset, `timeout_pulse` is 0.
- R2: With `wt_enable`=1, `wt_limit`=L>0, `tick_exp`=n (0..14), `xfer_active`=1 and `scl_in`=0 held from a clock edge on, `timeout_pulse` is 1 in exactly the cycle after the (L·2^n)-th rising edge and 0 before it.
- R3: `timeout_pulse` is high for one cycle only. It does not rise again while the conditions of R2 stay held.
- R4: A cycle with `scl_in`=1 clears both the elapsed count and the prescaler, and no pulse follows that cycle. A full L·2^n cycles of low SCL are needed again.
- R5: A cycle with `xfer_active`=0 clears the measurement in the same way as R4.
- R6: While `wt_enable`=0, the measurement is held at zero and `timeout_pulse` stays 0 however long SCL stays low.
- R7: A `wt_limit` of 0 disables the timer: `timeout_pulse` stays 0.
- R8: A `tick_exp` value of 15 behaves as 14, so a tick comes every 16384 clocks.
- R9: If `wt_limit` is lowered to a value at or below the ticks already elapsed, the pulse fires on the next tick.
- R10: After a clear (R4 to R7), a new low period fires a new pulse with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wt_enable | input | 1 | Timer enable |
| wt_limit | input | 15 | Timeout limit in ticks |
| tick_exp | input | 4 | Log2 of system clocks per tick |
| scl_in | input | 1 | Sampled SCL level |
| xfer_active | input | 1 | Master transfer in progress |
| timeout_pulse | output | 1 | One-cycle timeout indication |

## Verification
The hardest case to reach from the ports is the largest prescale setting. A timeout there needs tens of thousands of uninterrupted low cycles, and the clamp of exponent 15 only shows in the exact cycle the pulse lands. The stimulus therefore uses a limit of one tick, so the clamp is reached in 16384 cycles. The pulse cycle is located by counting edges from the moment the inputs are applied. A limit lowered mid-count is reached by holding SCL low at exponent 0 and then changing the limit between two edges.

// File: rtl/scl_stall_timer.sv
module scl_stall_timer #(
  parameter int LIMIT_W = 15,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wt_enable,
  input  logic [LIMIT_W-1:0] wt_limit,
  input  logic [EXP_W-1:0]   tick_exp,
  input  logic               scl_in,
  input  logic               xfer_active,
  output logic               timeout_pulse
);
  localparam int PRE_W = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [PRE_W-1:0]   pre_cnt;
  logic [LIMIT_W-1:0] tick_cnt;
  logic               fired;
  logic [EXP_W-1:0]   exp_eff;
  logic [PRE_W-1:0]   pre_mask;
  logic               armed, tick, hit;
  logic [LIMIT_W:0]   tick_nxt;

  assign exp_eff  = (tick_exp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : tick_exp;
  assign pre_mask = PRE_W'((32'd1 << exp_eff) - 32'd1);
  assign armed    = wt_enable && (wt_limit != '0) && xfer_active && !scl_in;
  assign tick     = armed && !fired && ((pre_cnt & pre_mask) == pre_mask);
  assign tick_nxt = {1'b0, tick_cnt} + 1'b1;
  assign hit      = tick && (tick_nxt >= {1'b0, wt_limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt       <= '0;
      tick_cnt      <= '0;
      fired         <= 1'b0;
      timeout_pulse <= 1'b0;
    end else if (!armed) begin
      pre_cnt       <= '0;
      tick_cnt      <= '0;
      fired         <= 1'b0;
      timeout_pulse <= 1'b0;
    end else begin
      timeout_pulse <= hit;
      if (hit) fired <= 1'b1;
      if (!fired) begin
        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        if (tick && !hit) tick_cnt <= tick_nxt[LIMIT_W-1:0];
      end
    end
  end
endmodule

module scl_stall_timer_chk #(
  parameter int LIMIT_W = 15,
  parameter int EXP_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wt_enable,
  input logic [LIMIT_W-1:0] wt_limit,
  input logic               scl_in,
  input logic               xfer_active,
  input logic               timeout_pulse
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else if (!wt_enable || !xfer_active || scl_in || wt_limit == '0) seen <= 1'b0;
    else if (timeout_pulse) seen <= 1'b1;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse); // R3
  AST_ONCE_PER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> !timeout_pulse); // R3
  AST_SCL_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    scl_in |=> !timeout_pulse); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> !timeout_pulse); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wt_enable |=> !timeout_pulse); // R6
  AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_limit == '0) |=> !timeout_pulse); // R7
endmodule

bind scl_stall_timer scl_stall_timer_chk #(.LIMIT_W(LIMIT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wt_enable(wt_enable), .wt_limit(wt_limit),
  .scl_in(scl_in), .xfer_active(xfer_active), .timeout_pulse(timeout_pulse));

// File: tb/scl_stall_timer_bench.sv
module scl_stall_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wt_enable = 1'b0, scl_in = 1'b1, xfer_active = 1'b0;
  logic [14:0] wt_limit = '0;
  logic [3:0]  tick_exp = '0;
  logic timeout_pulse;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  scl_stall_timer u_scl_stall_timer (
    .clk(clk), .rst_n(rst_n), .wt_enable(wt_enable), .wt_limit(wt_limit),
    .tick_exp(tick_exp), .scl_in(scl_in), .xfer_active(xfer_active),
    .timeout_pulse(timeout_pulse));

  task automatic check(input string req, input logic exp_v);
    n_chk++;
    if (timeout_pulse !== exp_v) begin
      n_bad++;
      $display("FAIL %s: timeout_pulse actual=%b expected=%b", req, timeout_pulse, exp_v);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    xfer_active = 1'b0; scl_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic arm(input logic [14:0] lim, input logic [3:0] e);
    wt_enable = 1'b1; wt_limit = lim; tick_exp = e;
    xfer_active = 1'b1; scl_in = 1'b0;
  endtask

  task automatic expect_at(input string req, input int n);
    for (int i = 1; i < n; i++) @(negedge clk);
    check(req, 1'b0);
    @(negedge clk); check(req, 1'b1);
    @(negedge clk); check(req, 1'b0);
  endtask

  task automatic quiet_for(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); check(req, 1'b0);
    end
  endtask

  task automatic t_reset();
    check("R1", 1'b0);
  endtask

  task automatic t_timing();
    arm(15'd7, 4'd0); expect_at("R2", 7); idle();
    arm(15'd3, 4'd2); expect_at("R2", 12); idle();
    arm(15'd5, 4'd3); expect_at("R2", 40);
    quiet_for("R3", 100); idle();
  endtask

  task automatic t_scl_high();
    arm(15'd4, 4'd1);
    for (int i = 0; i < 7; i++) @(negedge clk);
    scl_in = 1'b1; @(negedge clk); check("R4", 1'b0);
    scl_in = 1'b0; expect_at("R4", 8); idle();
  endtask

  task automatic t_xfer_idle();
    arm(15'd6, 4'd0);
    for (int i = 0; i < 5; i++) @(negedge clk);
    xfer_active = 1'b0; @(negedge clk); check("R5", 1'b0);
    xfer_active = 1'b1; expect_at("R5", 6); idle();
  endtask

  task automatic t_disabled();
    arm(15'd2, 4'd0); wt_enable = 1'b0;
    quiet_for("R6", 50);
    wt_enable = 1'b1; expect_at("R10", 2); idle();
  endtask

  task automatic t_zero_limit();
    arm(15'd0, 4'd0);
    quiet_for("R7", 60); idle();
  endtask

  task automatic t_exp_clamp();
    arm(15'd1, 4'd15); expect_at("R8", 16384); idle();
  endtask

  task automatic t_lower_limit();
    arm(15'd10, 4'd0);
    for (int i = 0; i < 5; i++) @(negedge clk);
    check("R9", 1'b0);
    wt_limit = 15'd3;
    @(negedge clk); check("R9", 1'b1);
    @(negedge clk); check("R9", 1'b0); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_scl_high();
    t_xfer_idle();
    t_disabled();
    t_zero_limit();
    t_lower_limit();
    t_exp_clamp();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule